// File: doc/BRIEF.md
# Color Channel Gain-Offset Sequencer

This block sits between a sensor front end's control register file and its conversion path. On every conversion clock it decides which color input is routed to the converter. It also passes on the gain code and offset code stored for that color. Four rotation policies are selected by a two-bit configuration field:
- a fixed red channel;
- red/green alternation for two-channel sensors;
- red, green and blue cycling on every clock for three-channel pixel-interleaved sensors;
- one color held per scan line, stepping red, green, blue at each line start.

A line-start level input (high for the duration of the line marker) sends the pixel-rate policies back to red and holds them there. A register-write strobe, or any change of the configuration field, restarts the rotation at red. In the pixel-rate policies the block also raises a one-clock simultaneous-sample strobe at the start of every red slot. Analog switch and clamp control are handled elsewhere; this block drives only the digital selection and the strobe.

Top module: `chan_rotator`

## Requirements
- R1: With configuration 0 (fixed), the color select is red (code 0) and the sample strobe stays low.
- R2: With configuration 2 (three-channel per pixel), the select steps red, green, blue, red on successive clocks once the red slot has started.
- R3: With configuration 1 (two-channel), the select alternates red and green on successive clocks and never shows blue (code 2).
- R4: With configuration 3 (per line), the select is held constant between line starts. Each rising edge of the line-start input loads the next color in the order red, green, blue, red. A line-start level that stays high for several clocks advances the order only once.
- R5: In configurations 1 and 2, while the line-start input is high the select is red and the strobe is low. On the first clock after it falls, a red slot begins and the strobe is raised.
- R6: A write strobe, or a configuration value that differs from the one sampled on the previous clock, forces the select to red with the strobe low. In configuration 3 it also makes the next line start load red. In configurations 1 and 2 the following clock is a red slot with the strobe.
- R7: The sample strobe is high only in configurations 1 and 2, only together with a red select, and once per rotation period (every third clock in configuration 2, every second clock in configuration 1).
- R8: The gain and offset outputs equal the fields of the selected color. Color code c (red 0, green 1, blue 2) occupies bits [c*W +: W] of the packed gain bank (W = 6) and of the packed offset bank (W = 8).
- R9: While reset is low, and on the first clock after it is released, the select is red and the strobe is low. After reset the configuration taken as previous is 0 and the next line color is red.
- All select and strobe outputs are registered: the inputs sampled at a rising clock edge take effect on the outputs right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_sync | input | 1 | Line-start marker, active high |
| cfg_mode | input | 2 | Rotation policy: 0 fixed, 1 two-channel, 2 three per pixel, 3 three per line |
| cfg_wr | input | 1 | One-clock strobe marking a write of the mode register |
| gain_bank | input | 18 | Packed gain codes, red in the low field |
| offs_bank | input | 24 | Packed offset codes, red in the low field |
| color_sel | output | 2 | Selected color: 0 red, 1 green, 2 blue |
| gain_sel | output | 6 | Gain code of the selected color |
| offs_sel | output | 8 | Offset code of the selected color |
| samp_strobe | output | 1 | Simultaneous-sample strobe at the start of a red slot |

## Verification
The properties assume that `cfg_mode`, `cfg_wr` and `line_sync` are synchronous to `clk` and free of unknowns after reset. They also treat a configuration change as the restart event itself, so no separate write strobe is needed. The stimulus changes every input only on the falling clock edge. It drives all inputs to known values before reset is released. It holds each configuration for several clocks and also steps it through the other policies, so every restart path and every line-start edge is exercised. The line-start level is held high for more than one clock in the per-line policy to show that it advances the order only once.

// File: rtl/chs_pkg.sv
package chs_pkg;

    localparam int NUM_COLORS = 3;
    localparam int COLOR_W    = 2;

    typedef enum logic [COLOR_W-1:0] {
        CLR_RED = 2'd0,
        CLR_GRN = 2'd1,
        CLR_BLU = 2'd2
    } color_e;

    typedef enum logic [1:0] {
        MD_FIX   = 2'd0,
        MD_DUAL  = 2'd1,
        MD_PIX3  = 2'd2,
        MD_LINE3 = 2'd3
    } mode_e;

    typedef struct packed {
        color_e color;
        color_e line_next;
        logic   idle;
        logic   strobe;
        mode_e  mode;
    } seq_state_t;

    // Next color in a rotation; two-color rotations skip blue.
    function automatic color_e step_color(color_e cur, logic two_only);
        color_e nxt;
        if (two_only) begin
            nxt = (cur == CLR_RED) ? CLR_GRN : CLR_RED;
        end else begin
            unique case (cur)
                CLR_RED: nxt = CLR_GRN;
                CLR_GRN: nxt = CLR_BLU;
                default: nxt = CLR_RED;
            endcase
        end
        return nxt;
    endfunction

endpackage

// File: rtl/chs_edge_det.sv
module chs_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise
);
    logic lvl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl;
    end

    assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/chs_field_sel.sv
module chs_field_sel
    import chs_pkg::*;
#(
    parameter int W = 6,
    parameter int N = NUM_COLORS
) (
    input  logic [N*W-1:0]     bank,
    input  logic [COLOR_W-1:0] sel,
    output logic [W-1:0]       field
);
    logic [W-1:0] slot [N];

    for (genvar i = 0; i < N; i++) begin : g_slot
        assign slot[i] = bank[i*W +: W];
    end

    always_comb begin
        field = '0;
        for (int i = 0; i < N; i++) begin
            if (sel == COLOR_W'(i)) field = slot[i];
        end
    end
endmodule

// File: rtl/chan_rotator.sv
module chan_rotator
    import chs_pkg::*;
#(
    parameter int GAIN_W = 6,
    parameter int OFFS_W = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         line_sync,
    input  logic [1:0]                   cfg_mode,
    input  logic                         cfg_wr,
    input  logic [NUM_COLORS*GAIN_W-1:0] gain_bank,
    input  logic [NUM_COLORS*OFFS_W-1:0] offs_bank,
    output logic [COLOR_W-1:0]           color_sel,
    output logic [GAIN_W-1:0]            gain_sel,
    output logic [OFFS_W-1:0]            offs_sel,
    output logic                         samp_strobe
);
    localparam seq_state_t RESET_STATE = '{
        color:     CLR_RED,
        line_next: CLR_RED,
        idle:      1'b1,
        strobe:    1'b0,
        mode:      MD_FIX
    };

    seq_state_t st_d, st_q;
    logic       sync_rise;
    logic       restart;
    mode_e      mode_now;

    chs_edge_det u_sync_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (line_sync),
        .rise (sync_rise)
    );

    assign mode_now = mode_e'(cfg_mode);
    assign restart  = cfg_wr || (mode_now != st_q.mode);

    always_comb begin
        st_d        = st_q;
        st_d.mode   = mode_now;
        st_d.strobe = 1'b0;
        unique case (mode_now)
            MD_FIX: begin
                st_d.color     = CLR_RED;
                st_d.line_next = CLR_RED;
                st_d.idle      = 1'b1;
            end
            MD_DUAL, MD_PIX3: begin
                st_d.line_next = CLR_RED;
                if (restart || line_sync) begin
                    st_d.color = CLR_RED;
                    st_d.idle  = 1'b1;
                end else if (st_q.idle) begin
                    st_d.color  = CLR_RED;
                    st_d.idle   = 1'b0;
                    st_d.strobe = 1'b1;
                end else begin
                    st_d.color  = step_color(st_q.color, mode_now == MD_DUAL);
                    st_d.strobe = (st_d.color == CLR_RED);
                end
            end
            MD_LINE3: begin
                st_d.idle = 1'b1;
                if (restart) begin
                    st_d.color     = CLR_RED;
                    st_d.line_next = CLR_RED;
                end else if (sync_rise) begin
                    st_d.color     = st_q.line_next;
                    st_d.line_next = step_color(st_q.line_next, 1'b0);
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RESET_STATE;
        else        st_q <= st_d;
    end

    assign color_sel   = st_q.color;
    assign samp_strobe = st_q.strobe;

    chs_field_sel #(.W(GAIN_W), .N(NUM_COLORS)) u_gain_sel (
        .bank (gain_bank),
        .sel  (st_q.color),
        .field(gain_sel)
    );

    chs_field_sel #(.W(OFFS_W), .N(NUM_COLORS)) u_offs_sel (
        .bank (offs_bank),
        .sel  (st_q.color),
        .field(offs_sel)
    );
endmodule

// File: rtl/chan_rotator_chk.sv
module chan_rotator_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       line_sync,
    input logic [1:0] cfg_mode,
    input logic       cfg_wr,
    input logic [1:0] color_sel,
    input logic       samp_strobe
);
    AST_FIXED_RED: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'd0) |=> (color_sel == 2'd0 && !samp_strobe)); // R1

    AST_PIX3_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'd2 && $past(cfg_mode) == 2'd2 && !line_sync && !cfg_wr
         && color_sel == 2'd1) |=> (color_sel == 2'd2)); // R2

    AST_DUAL_NO_BLUE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'd1) |=> (color_sel != 2'd2)); // R3

    AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'd3 && $past(cfg_mode) == 2'd3 && !cfg_wr
         && !(line_sync && !$past(line_sync))) |=> $stable(color_sel)); // R4

    AST_SYNC_RED: assert property (@(posedge clk) disable iff (!rst_n)
        (line_sync && (cfg_mode == 2'd1 || cfg_mode == 2'd2))
        |=> (color_sel == 2'd0 && !samp_strobe)); // R5

    AST_WRITE_RED: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (color_sel == 2'd0 && !samp_strobe)); // R6

    AST_STROBE_RED: assert property (@(posedge clk) disable iff (!rst_n)
        samp_strobe |-> (color_sel == 2'd0)); // R7

    AST_LINE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'd3) |=> !samp_strobe); // R7
endmodule

bind chan_rotator chan_rotator_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_sync  (line_sync),
    .cfg_mode   (cfg_mode),
    .cfg_wr     (cfg_wr),
    .color_sel  (color_sel),
    .samp_strobe(samp_strobe)
);

// File: tb/tb_chan_rotator.sv
module tb_chan_rotator;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_sync = 1'b0;
    logic [1:0]  cfg_mode = 2'd0;
    logic        cfg_wr = 1'b0;
    logic [17:0] gain_bank = {6'd50, 6'd33, 6'd17};
    logic [23:0] offs_bank = {8'hC3, 8'h5A, 8'h0F};
    logic [1:0]  color_sel;
    logic [5:0]  gain_sel;
    logic [7:0]  offs_sel;
    logic        samp_strobe;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    chan_rotator dut (
        .clk(clk), .rst_n(rst_n), .line_sync(line_sync), .cfg_mode(cfg_mode),
        .cfg_wr(cfg_wr), .gain_bank(gain_bank), .offs_bank(offs_bank),
        .color_sel(color_sel), .gain_sel(gain_sel), .offs_sel(offs_sel),
        .samp_strobe(samp_strobe)
    );

    // {sync, mode[1:0], wr, expected color[1:0], expected strobe}
    localparam int NV = 38;
    localparam logic [6:0] VEC [NV] = '{
        7'b0_00_0_00_0, 7'b0_00_0_00_0,                 // R1 fixed
        7'b0_10_0_00_0, 7'b0_10_0_00_1, 7'b0_10_0_01_0, // R2 start
        7'b0_10_0_10_0, 7'b0_10_0_00_1, 7'b0_10_0_01_0,
        7'b1_10_0_00_0, 7'b1_10_0_00_0, 7'b0_10_0_00_1, // R5 sync
        7'b0_10_0_01_0,
        7'b0_01_0_00_0, 7'b0_01_0_00_1, 7'b0_01_0_01_0, // R3 dual
        7'b0_01_0_00_1, 7'b0_01_0_01_0,
        7'b0_11_1_00_0, 7'b1_11_0_00_0, 7'b1_11_0_00_0, // R4 line
        7'b0_11_0_00_0, 7'b1_11_0_01_0, 7'b0_11_0_01_0,
        7'b1_11_0_10_0, 7'b0_11_0_10_0, 7'b1_11_0_00_0,
        7'b0_11_0_00_0, 7'b1_11_0_01_0,
        7'b0_11_1_00_0, 7'b1_11_0_00_0, 7'b0_11_0_00_0, // R6 write
        7'b1_11_0_01_0,
        7'b0_00_0_00_0, 7'b0_10_0_00_0, 7'b0_10_0_00_1,
        7'b0_10_0_01_0, 7'b0_10_1_00_0, 7'b0_10_0_00_1
    };

    function automatic string req_of(logic [6:0] v);
        if (v[3])                                   return "R6";
        if (v[6] && (v[5:4] == 2'd1 || v[5:4] == 2'd2)) return "R5";
        if (v[0])                                   return "R7";
        case (v[5:4])
            2'd0:    return "R1";
            2'd1:    return "R3";
            2'd2:    return "R2";
            default: return "R4";
        endcase
    endfunction

    task automatic check_out(string req, logic [1:0] exp_col, logic exp_stb);
        logic [5:0] exp_g;
        logic [7:0] exp_o;
        exp_g = gain_bank[exp_col*6 +: 6];
        exp_o = offs_bank[exp_col*8 +: 8];
        checks++;
        if (color_sel !== exp_col || samp_strobe !== exp_stb) begin
            errors++;
            $display("FAIL %s: color=%0d strobe=%0b expected color=%0d strobe=%0b",
                     req, color_sel, samp_strobe, exp_col, exp_stb);
        end
        checks++;
        if (gain_sel !== exp_g || offs_sel !== exp_o) begin // R8
            errors++;
            $display("FAIL R8: gain=%0d offs=%0h expected gain=%0d offs=%0h",
                     gain_sel, offs_sel, exp_g, exp_o);
        end
    endtask

    task automatic drive(logic s, logic [1:0] m, logic w);
        line_sync = s;
        cfg_mode  = m;
        cfg_wr    = w;
    endtask

    initial begin
        repeat (2) @(negedge clk);
        check_out("R9", 2'd0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check_out("R9", 2'd0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][6], VEC[i][5:4], VEC[i][3]);
            @(negedge clk);
            check_out(req_of(VEC[i]), VEC[i][2:1], VEC[i][0]);
        end

        // R9: reset mid-rotation returns to red
        drive(1'b0, 2'd2, 1'b0);
        repeat (2) @(negedge clk);
        rst_n = 1'b0;
        #1;
        check_out("R9", 2'd0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_out("R6", 2'd0, 1'b0);   // configuration differs from reset value
        @(negedge clk);
        check_out("R7", 2'd0, 1'b1);
        @(negedge clk);
        check_out("R2", 2'd1, 1'b0);

        // R8: bank change while blue is selected shows through at once
        @(negedge clk);
        gain_bank[17:12] = 6'd63;
        offs_bank[23:16] = 8'hEE;
        #1;
        check_out("R8", 2'd2, 1'b0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule